// File: doc/BRIEF.md
# Host Register Port with Latch-Synchronised Interrupt

This block is the host-side register window of a fieldbus register-expansion slice. A local processor reaches twelve byte-wide IN registers, whose contents go out on the fieldbus, and twelve OUT registers, which arrive from the fieldbus. It also reaches one configuration byte and one interrupt-acknowledge location. All of these sit in a 16-location space. The host uses active-low read and write strobes and three active-low enables: one for configuration, one for data reads and one for data writes. All of these inputs are asynchronous to the block clock. They pass through synchronisers, and edges are found on the synchronised copies.

The shift chain that moves data over the fieldbus is not part of this block. It reads the IN bytes from a flat parallel output. It hands OUT bytes to the block on a parallel input, together with an OUT-latch strobe. A second strobe, the IN-latch, marks the instant the fieldbus takes its data. When enabled, its rising edge raises an active-low interrupt. The host can then do its accesses away from that instant. The host clears the interrupt by reading the configuration address. A fieldbus-side register clear empties the data registers but keeps the configuration.

Top module: `hostreg_port`

## Requirements
- R1: Address k (0 to 11) selects IN byte k for writes and OUT byte k for reads. IN byte k appears on `in_par[8k+7:8k]`, and OUT byte k is taken from `out_par[8k+7:8k]`.
- R2: A write takes effect on the synchronised rising edge of `wr_n`, using the address and data held at that point. A data write needs `cs_wr_n` low and a configuration write needs `cs_cfg_n` low; without the matching enable nothing changes.
- R3: `rdata_oe` is high only while `rd_n` is low and the address is enabled for reading: `cs_rd_n` low for addresses 0 to 11 and 13 to 15, `cs_cfg_n` low for address 12. It drops as soon as `rd_n` returns high.
- R4: A write to address 12 loads the configuration. Bit 0 picks the length source (0 = `len_pins`, 1 = register). Bits 3:1 hold the length code. Bit 4 enables the interrupt. Bits 7:5 are not stored. `len_eff` shows the selected length code.
- R5: Addresses 13 to 15 read as 0x00, and writes to them change no register.
- R6: While bit 4 of the configuration is set, each synchronised rising edge of `in_latch` drives `irq_n` low. While bit 4 is clear, `irq_n` does not change.
- R7: A read of address 12 with `cs_cfg_n` low returns `irq_n` high at the rising edge of `rd_n`.
- R8: When an interrupt-setting edge and an acknowledging read edge fall in the same cycle, `irq_n` ends low.
- R9: `fb_clr` high for a cycle clears all IN and OUT registers and leaves the configuration unchanged.
- R10: `rst_n` low clears the data registers and the configuration to 0x00 and sets `irq_n` high. The length then follows `len_pins`, and the interrupt is disabled.
- R11: A synchronised rising edge of `out_latch` copies `out_par` into the OUT registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, clears everything |
| fb_clr | input | 1 | Synchronous fieldbus register clear, active high |
| addr | input | 4 | Host address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| rdata_oe | output | 1 | Read-data drive enable for the pad |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_cfg_n | input | 1 | Configuration access enable, active low |
| cs_rd_n | input | 1 | Data read enable, active low |
| cs_wr_n | input | 1 | Data write enable, active low |
| irq_n | output | 1 | Interrupt request, active low |
| in_latch | input | 1 | IN-latch strobe from the fieldbus side |
| out_latch | input | 1 | OUT-latch strobe from the fieldbus side |
| len_pins | input | 3 | Length code from strapping pins |
| len_eff | output | 3 | Selected length code |
| in_par | output | 96 | IN bytes, byte k at bits 8k+7:8k |
| out_par | input | 96 | OUT bytes from the shift chain |

## Verification
The interrupt has two sources of change: the set from an IN-latch edge and the clear from an acknowledging read of address 12. The bench makes both happen in one cycle by raising `rd_n` and `in_latch` at the same instant. Both signals pass through synchronisers of equal depth, so their edges are seen together. The case is run both with an interrupt already pending and with none pending. It passes only if `irq_n` is low afterwards. A following lone acknowledge must then return it high.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
    localparam int unsigned LEN_W = 3;
    localparam int unsigned CFG_W = 5;

    // Stored configuration bits, packed MSB first so that bit positions
    // match the host byte: [4] irq enable, [3:1] length code, [0] source.
    typedef struct packed {
        logic             irq_en;
        logic [LEN_W-1:0] len;
        logic             len_src;
    } cfg_t;
endpackage

// File: rtl/hostreg_sync.sv
module hostreg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/hostreg_decode.sv
module hostreg_decode #(
    parameter int unsigned NBYTES = 12,
    parameter int unsigned AW     = 4
) (
    input  logic [AW-1:0] addr,
    input  logic          cs_cfg_n,
    input  logic          cs_rd_n,
    input  logic          cs_wr_n,
    output logic          rd_data_hit,
    output logic          rd_cfg_hit,
    output logic          rd_sel,
    output logic          wr_data_hit,
    output logic          wr_cfg_hit
);
    localparam logic [AW-1:0] CFG_ADDR = AW'(NBYTES);

    logic in_data, in_cfg, in_spare;

    always_comb begin
        in_data     = addr < CFG_ADDR;
        in_cfg      = addr == CFG_ADDR;
        in_spare    = addr > CFG_ADDR;
        rd_data_hit = in_data & ~cs_rd_n;
        rd_cfg_hit  = in_cfg & ~cs_cfg_n;
        rd_sel      = rd_data_hit | rd_cfg_hit | (in_spare & ~cs_rd_n);
        wr_data_hit = in_data & ~cs_wr_n;
        wr_cfg_hit  = in_cfg & ~cs_cfg_n;
    end
endmodule

// File: rtl/hostreg_irq.sv
module hostreg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_i) pend_d = 1'b0;
        if (set_i) pend_d = 1'b1;   // set takes priority over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign irq_n_o = ~pend_q;
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hostreg_pkg::*;
#(
    parameter int unsigned NBYTES      = 12,
    parameter int unsigned DW          = 8,
    parameter int unsigned AW          = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fb_clr,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 rdata_oe,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 cs_cfg_n,
    input  logic                 cs_rd_n,
    input  logic                 cs_wr_n,
    output logic                 irq_n,
    input  logic                 in_latch,
    input  logic                 out_latch,
    input  logic [LEN_W-1:0]     len_pins,
    output logic [LEN_W-1:0]     len_eff,
    output logic [NBYTES*DW-1:0] in_par,
    input  logic [NBYTES*DW-1:0] out_par
);
    localparam int unsigned NSTROBE = 4;
    localparam int unsigned S_RD = 0, S_WR = 1, S_INL = 2, S_OUTL = 3;
    localparam logic [NSTROBE-1:0] IDLE_HIGH = 4'b0011;

    typedef struct packed {
        logic [NBYTES-1:0][DW-1:0] in_b;
        logic [NBYTES-1:0][DW-1:0] out_b;
        cfg_t                      cfg;
    } state_t;

    state_t st_d, st_q;

    logic [NSTROBE-1:0] strobe_raw, strobe_lvl, strobe_rise;
    logic rd_data_hit, rd_cfg_hit, rd_sel, wr_data_hit, wr_cfg_hit;
    logic data_we, cfg_we, irq_set, irq_clr;
    cfg_t cfg_cur;

    assign strobe_raw = {out_latch, in_latch, wr_n, rd_n};

    for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
        hostreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_HIGH[g])) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (strobe_raw[g]),
            .level_o (strobe_lvl[g]),
            .rise_o  (strobe_rise[g])
        );
    end

    hostreg_decode #(.NBYTES(NBYTES), .AW(AW)) u_dec (
        .addr        (addr),
        .cs_cfg_n    (cs_cfg_n),
        .cs_rd_n     (cs_rd_n),
        .cs_wr_n     (cs_wr_n),
        .rd_data_hit (rd_data_hit),
        .rd_cfg_hit  (rd_cfg_hit),
        .rd_sel      (rd_sel),
        .wr_data_hit (wr_data_hit),
        .wr_cfg_hit  (wr_cfg_hit)
    );

    assign data_we = strobe_rise[S_WR] & wr_data_hit;
    assign cfg_we  = strobe_rise[S_WR] & wr_cfg_hit;
    assign irq_set = strobe_rise[S_INL] & st_q.cfg.irq_en;
    assign irq_clr = strobe_rise[S_RD] & rd_cfg_hit;

    always_comb begin
        st_d = st_q;
        if (strobe_rise[S_OUTL]) st_d.out_b = out_par;
        if (data_we)             st_d.in_b[addr] = wdata;
        if (cfg_we)              st_d.cfg = cfg_t'(wdata[CFG_W-1:0]);
        if (fb_clr) begin
            st_d.in_b  = '0;
            st_d.out_b = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    hostreg_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (irq_set),
        .clr_i   (irq_clr),
        .irq_n_o (irq_n)
    );

    // Read path follows the raw strobe so the bus is released at once.
    assign rdata_oe = ~rd_n & rd_sel;
    assign rdata    = rd_data_hit ? st_q.out_b[addr] : '0;
    assign cfg_cur  = st_q.cfg;
    assign len_eff  = cfg_cur.len_src ? cfg_cur.len : len_pins;
    assign in_par   = st_q.in_b;

    logic unused_lvl;
    assign unused_lvl = ^strobe_lvl;
endmodule

// File: rtl/hostreg_chk.sv
module hostreg_chk
    import hostreg_pkg::*;
#(
    parameter int unsigned NBYTES = 12,
    parameter int unsigned DW     = 8,
    parameter int unsigned AW     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fb_clr,
    input logic [AW-1:0]        addr,
    input logic [DW-1:0]        rdata,
    input logic                 rdata_oe,
    input logic                 irq_n,
    input logic                 irq_set,
    input logic                 irq_clr,
    input logic                 cfg_we,
    input cfg_t                 cfg_cur,
    input logic [NBYTES*DW-1:0] in_par
);
    localparam logic [AW-1:0] CFG_ADDR = AW'(NBYTES);

    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> !irq_n);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !irq_set |=> irq_n);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && irq_set |=> !irq_n);

    p_data_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fb_clr |=> in_par == '0);

    p_cfg_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fb_clr && !cfg_we |=> cfg_cur == $past(cfg_cur));

    p_spare_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe && addr > CFG_ADDR |-> rdata == '0);
endmodule

bind hostreg_port hostreg_chk #(.NBYTES(NBYTES), .DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fb_clr   (fb_clr),
    .addr     (addr),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .irq_n    (irq_n),
    .irq_set  (irq_set),
    .irq_clr  (irq_clr),
    .cfg_we   (cfg_we),
    .cfg_cur  (cfg_cur),
    .in_par   (in_par)
);

// File: tb/tb_hostreg_port.sv
`timescale 1ns/1ps
module tb_hostreg_port;
    localparam int NB = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0, fb_clr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic rdata_oe, irq_n;
    logic rd_n = 1'b1, wr_n = 1'b1;
    logic cs_cfg_n = 1'b1, cs_rd_n = 1'b1, cs_wr_n = 1'b1;
    logic in_latch = 1'b0, out_latch = 1'b0;
    logic [2:0] len_pins = 3'd5, len_eff;
    logic [NB*8-1:0] in_par, out_par = '0;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hostreg_port dut (
        .clk(clk), .rst_n(rst_n), .fb_clr(fb_clr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .rd_n(rd_n), .wr_n(wr_n),
        .cs_cfg_n(cs_cfg_n), .cs_rd_n(cs_rd_n), .cs_wr_n(cs_wr_n),
        .irq_n(irq_n), .in_latch(in_latch), .out_latch(out_latch),
        .len_pins(len_pins), .len_eff(len_eff), .in_par(in_par), .out_par(out_par)
    );

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sel: 0 data enable, 1 config enable, 2 no enable
    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input int sel);
        @(negedge clk);
        addr = a; wdata = d;
        cs_wr_n = (sel != 0); cs_cfg_n = (sel != 1);
        wr_n = 1'b0;
        idle(3);
        wr_n = 1'b1;
        idle(5);
        cs_wr_n = 1'b1; cs_cfg_n = 1'b1;
        idle(1);
    endtask

    task automatic do_read(input logic [3:0] a, input int sel,
                           output logic [7:0] d, output logic oe, output logic oe_after);
        @(negedge clk);
        addr = a;
        cs_rd_n = (sel != 0); cs_cfg_n = (sel != 1);
        rd_n = 1'b0;
        idle(2);
        d = rdata; oe = rdata_oe;
        idle(1);
        rd_n = 1'b1;
        #0.5 oe_after = rdata_oe;
        idle(5);
        cs_rd_n = 1'b1; cs_cfg_n = 1'b1;
        idle(1);
    endtask

    task automatic pulse_latch();
        @(negedge clk);
        in_latch = 1'b1;
        idle(5);
        in_latch = 1'b0;
        idle(4);
    endtask

    // acknowledging read and latch edge released at the same instant
    task automatic ack_with_latch();
        @(negedge clk);
        addr = 4'd12; cs_cfg_n = 1'b0; rd_n = 1'b0;
        idle(3);
        rd_n = 1'b1; in_latch = 1'b1;
        idle(5);
        cs_cfg_n = 1'b1; in_latch = 1'b0;
        idle(4);
    endtask

    function automatic logic [7:0] in_pat(input int k);
        return 8'((k * 37 + 11) & 8'hFF);
    endfunction

    function automatic logic [7:0] out_pat(input int k);
        return 8'((k * 53 + 200) & 8'hFF);
    endfunction

    initial begin
        logic [7:0] d;
        logic oe, oe_after;
        logic [95:0] snap;

        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R10 reset state
        chk("R10 irq_n after reset", 96'(irq_n), 96'd1);
        chk("R10 in_par after reset", 96'(in_par), 96'd0);
        chk("R10 length follows pins", 96'(len_eff), 96'd5);
        chk("R3 no drive when idle", 96'(rdata_oe), 96'd0);

        // R1 R2 write sweep of IN bytes
        for (int k = 0; k < NB; k++) begin
            do_write(4'(k), in_pat(k), 0);
            chk($sformatf("R1 IN byte %0d", k), 96'(in_par[k*8 +: 8]), 96'(in_pat(k)));
        end
        snap = in_par;

        // R2 write without the data enable is dropped
        do_write(4'd2, 8'h55, 1);
        chk("R2 write without data enable", in_par, snap);
        do_write(4'd7, 8'hAA, 2);
        chk("R2 write with no enable", in_par, snap);

        // R5 writes to spare addresses change nothing
        for (int a = 13; a < 16; a++) begin
            do_write(4'(a), 8'hFF, 0);
            do_write(4'(a), 8'hFF, 1);
            chk($sformatf("R5 spare write %0d IN", a), in_par, snap);
            chk($sformatf("R5 spare write %0d len", a), 96'(len_eff), 96'd5);
        end

        // R11 R1 OUT load and read sweep
        for (int k = 0; k < NB; k++) out_par[k*8 +: 8] = out_pat(k);
        @(negedge clk); out_latch = 1'b1; idle(5); out_latch = 1'b0; idle(4);
        for (int k = 0; k < NB; k++) begin
            do_read(4'(k), 0, d, oe, oe_after);
            chk($sformatf("R11 OUT byte %0d", k), 96'(d), 96'(out_pat(k)));
            chk($sformatf("R3 drive during read %0d", k), 96'(oe), 96'd1);
            chk($sformatf("R3 release after read %0d", k), 96'(oe_after), 96'd0);
        end

        // R5 spare addresses read as zero
        for (int a = 13; a < 16; a++) begin
            do_read(4'(a), 0, d, oe, oe_after);
            chk($sformatf("R5 spare read %0d data", a), 96'(d), 96'd0);
            chk($sformatf("R5 spare read %0d drive", a), 96'(oe), 96'd1);
        end

        // R3 read without enable does not drive
        do_read(4'd4, 2, d, oe, oe_after);
        chk("R3 no enable no drive", 96'(oe), 96'd0);
        do_read(4'd4, 1, d, oe, oe_after);
        chk("R3 config enable on data addr", 96'(oe), 96'd0);

        // R4 register length source
        for (int c = 0; c < 8; c++) begin
            do_write(4'd12, 8'((c << 1) | 1), 1);
            chk($sformatf("R4 reg length %0d", c), 96'(len_eff), 96'(c));
        end
        do_write(4'd12, 8'hE0, 1);
        for (int p = 0; p < 8; p++) begin
            len_pins = 3'(p);
            idle(1);
            chk($sformatf("R4 pin length %0d", p), 96'(len_eff), 96'(p));
        end
        len_pins = 3'd5;

        // R6 R7 interrupt set and acknowledge
        do_write(4'd12, 8'h10, 1);
        chk("R6 idle before latch", 96'(irq_n), 96'd1);
        pulse_latch();
        chk("R6 latch edge sets irq", 96'(irq_n), 96'd0);
        do_read(4'd12, 1, d, oe, oe_after);
        chk("R7 acknowledge clears irq", 96'(irq_n), 96'd1);
        chk("R3 config read drives", 96'(oe), 96'd1);
        do_read(4'd12, 0, d, oe, oe_after);
        pulse_latch();
        do_read(4'd12, 0, d, oe, oe_after);
        chk("R7 wrong enable does not clear", 96'(irq_n), 96'd0);
        do_read(4'd12, 1, d, oe, oe_after);
        chk("R7 clear again", 96'(irq_n), 96'd1);

        // R6 disabled interrupt
        do_write(4'd12, 8'h00, 1);
        pulse_latch();
        chk("R6 disabled latch ignored", 96'(irq_n), 96'd1);

        // R8 set and clear in one cycle
        do_write(4'd12, 8'h10, 1);
        ack_with_latch();
        chk("R8 coincident, none pending", 96'(irq_n), 96'd0);
        ack_with_latch();
        chk("R8 coincident, already pending", 96'(irq_n), 96'd0);
        do_read(4'd12, 1, d, oe, oe_after);
        chk("R8 lone acknowledge after", 96'(irq_n), 96'd1);

        // R9 fieldbus clear keeps configuration
        do_write(4'd12, 8'h17, 1);
        @(negedge clk); fb_clr = 1'b1; @(negedge clk); fb_clr = 1'b0; idle(1);
        chk("R9 IN bytes cleared", in_par, 96'd0);
        do_read(4'd3, 0, d, oe, oe_after);
        chk("R9 OUT bytes cleared", 96'(d), 96'd0);
        chk("R9 config kept", 96'(len_eff), 96'd3);
        pulse_latch();
        chk("R9 irq enable kept", 96'(irq_n), 96'd0);

        // R10 power-on reset clears configuration and interrupt
        do_write(4'd0, 8'h99, 0);
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(2);
        chk("R10 irq released", 96'(irq_n), 96'd1);
        chk("R10 length back to pins", 96'(len_eff), 96'd5);
        chk("R10 data cleared", in_par, 96'd0);
        pulse_latch();
        chk("R10 irq disabled after reset", 96'(irq_n), 96'd1);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL all requirements: watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule